// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out where an instruction's operand lives for a small CPU with 16-bit addresses. The decoder hands it an addressing-mode code, the operand size, the value read from the selected register, the instruction's extension field and the address of the next instruction. It then raises a start strobe. One cycle later the block returns the effective address. For modes that do not name memory, it instead returns a flag saying the operand is a register or an immediate value. It also returns an optional register write-back for the auto-stepping modes.

One mode addresses memory through a pointer held in the bottom 256-byte page. In that mode the block issues a word read request, holds it until the memory acknowledges, and then reports the fetched word as the address. While that fetch is in flight, new start strobes are ignored. Decode, operand access and execution belong to other blocks.

Top module: `ea_unit`

## Requirements
- R1: Mode 0 (register direct), and the unused codes 11 to 15, give valid with is_reg=1, is_imm=0, wb_en=0 and ea=0.
- R2: Mode 1 (register indirect) gives ea equal to reg_val.
- R3: Mode 2 (register plus displacement) gives ea = reg_val + field, modulo 2^16.
- R4: Mode 3 (post-increment) gives ea = reg_val, wb_en=1 and wb_val = reg_val + step. The step is 1 when size_word=0 and 2 when size_word=1, and the sum wraps modulo 2^16.
- R5: Mode 4 (pre-decrement) gives wb_en=1 and ea = wb_val = reg_val - step, with the same step and wrap as R4.
- R6: Mode 5 (short absolute) gives ea = {8'hFF, field[7:0]}.
- R7: Mode 6 (long absolute) gives ea = field.
- R8: Mode 7 (PC relative) gives ea = pc + sign-extended field[7:0], modulo 2^16. The pc input is used exactly as given.
- R9: Mode 8 (memory indirect) raises mem_req with mem_addr = {8'h00, field[7:0]} in the cycle after start. It holds both unchanged until mem_ack is sampled high, then drops mem_req. The result has ea = mem_rdata, with is_reg=0, is_imm=0 and wb_en=0.
- R10: valid rises in the cycle after an accepted start for modes other than 8. For mode 8 it rises in the cycle after the acknowledge. It lasts one cycle unless a new result follows.
- R11: Modes 9 and 10 (immediate) give is_imm=1, wb_en=0, no memory request, and data_out equal to field[7:0] zero-extended (mode 9) or field (mode 10). In every other mode data_out is 0.
- R12: A start that arrives while a memory-indirect fetch is outstanding has no effect.
- R13: During reset valid, wb_en and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation |
| mode | input | 4 | Addressing-mode code |
| size_word | input | 1 | 1 = word operand, 0 = byte operand |
| reg_val | input | 16 | Contents of the selected register |
| field | input | 16 | Displacement, absolute or immediate field |
| pc | input | 16 | Address of the following instruction |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | 16 | Word returned by memory |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Pointer address being read |
| valid | output | 1 | Result strobe |
| ea | output | 16 | Effective address |
| data_out | output | 16 | Immediate operand value |
| is_reg | output | 1 | Operand is the register itself |
| is_imm | output | 1 | Operand is the immediate value |
| wb_en | output | 1 | Register write-back enable |
| wb_val | output | 16 | Register write-back value |

## Verification
A faulty step, carry or sign extension shows up as a wrong ea or wb_val in the very next cycle after start, because all address modes are resolved in a single registered stage. A fetch controller stuck in the wrong state shows up right after the request cycle. It appears either as a mem_req that drops before the acknowledge, or as a valid pulse that comes without one, or as an accepted start during the wait. A missing or extra valid pulse can be seen one cycle after the start or the acknowledge.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W  = 16;
  localparam int SHORT_W = 8;
  localparam int MODE_W  = 4;
  localparam int PAGE_W  = ADDR_W - SHORT_W;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [SHORT_W-1:0] short_t;

  typedef enum logic [MODE_W-1:0] {
    AM_REG     = 4'd0,
    AM_IND     = 4'd1,
    AM_DISP    = 4'd2,
    AM_POSTINC = 4'd3,
    AM_PREDEC  = 4'd4,
    AM_ABS_S   = 4'd5,
    AM_ABS_L   = 4'd6,
    AM_PCREL   = 4'd7,
    AM_MEMIND  = 4'd8,
    AM_IMM_S   = 4'd9,
    AM_IMM_L   = 4'd10
  } amode_e;

  typedef struct packed {
    addr_t ea;
    addr_t data;
    addr_t wb_val;
    logic  wb_en;
    logic  is_reg;
    logic  is_imm;
    logic  need_mem;
    addr_t ptr;
  } ea_res_t;

  function automatic addr_t step_of(input logic word);
    return word ? addr_t'(2) : addr_t'(1);
  endfunction

  function automatic addr_t top_page(input short_t s);
    return {{PAGE_W{1'b1}}, s};
  endfunction

  function automatic addr_t bottom_page(input short_t s);
    return {{PAGE_W{1'b0}}, s};
  endfunction

  function automatic addr_t sext_short(input short_t s);
    return {{PAGE_W{s[SHORT_W-1]}}, s};
  endfunction

  function automatic addr_t add_wrap(input addr_t a, input addr_t b);
    return a + b;
  endfunction

  function automatic addr_t sub_wrap(input addr_t a, input addr_t b);
    return a - b;
  endfunction
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              size_word,
  input  addr_t             reg_val,
  input  addr_t             field,
  input  addr_t             pc,
  output ea_res_t           res
);
  addr_t  step;
  short_t fshort;

  assign step   = step_of(size_word);
  assign fshort = field[SHORT_W-1:0];

  always_comb begin
    res = '0;
    case (mode)
      AM_IND:     res.ea = reg_val;
      AM_DISP:    res.ea = add_wrap(reg_val, field);
      AM_POSTINC: begin
        res.ea     = reg_val;
        res.wb_en  = 1'b1;
        res.wb_val = add_wrap(reg_val, step);
      end
      AM_PREDEC:  begin
        res.ea     = sub_wrap(reg_val, step);
        res.wb_en  = 1'b1;
        res.wb_val = sub_wrap(reg_val, step);
      end
      AM_ABS_S:   res.ea = top_page(fshort);
      AM_ABS_L:   res.ea = field;
      AM_PCREL:   res.ea = add_wrap(pc, sext_short(fshort));
      AM_MEMIND:  begin
        res.need_mem = 1'b1;
        res.ptr      = bottom_page(fshort);
      end
      AM_IMM_S:   begin
        res.is_imm = 1'b1;
        res.data   = bottom_page(fshort);
      end
      AM_IMM_L:   begin
        res.is_imm = 1'b1;
        res.data   = field;
      end
      default:    res.is_reg = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_fetch.sv
module ea_fetch
  import ea_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  addr_t ptr_in,
  input  logic  mem_ack,
  output logic  mem_req,
  output addr_t mem_addr,
  output logic  busy,
  output logic  done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
    end else if (mem_req) begin
      if (mem_ack) mem_req <= 1'b0;
    end else if (launch) begin
      mem_req  <= 1'b1;
      mem_addr <= ptr_in;
    end
  end

  assign busy = mem_req;
  assign done = mem_req && mem_ack;

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  a_r9_bottom_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[ADDR_W-1:SHORT_W] == '0);
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [3:0]  mode,
  input  logic        size_word,
  input  logic [15:0] reg_val,
  input  logic [15:0] field,
  input  logic [15:0] pc,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  output logic        valid,
  output logic [15:0] ea,
  output logic [15:0] data_out,
  output logic        is_reg,
  output logic        is_imm,
  output logic        wb_en,
  output logic [15:0] wb_val
);
  ea_res_t res;
  logic    busy;
  logic    accept;
  logic    fetch_done;
  logic    launch;
  logic    direct_done;

  ea_calc u_calc (
    .mode      (mode),
    .size_word (size_word),
    .reg_val   (reg_val),
    .field     (field),
    .pc        (pc),
    .res       (res)
  );

  assign accept      = start && !busy;
  assign launch      = accept && res.need_mem;
  assign direct_done = accept && !res.need_mem;

  ea_fetch u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .ptr_in   (res.ptr),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .busy     (busy),
    .done     (fetch_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      wb_en    <= 1'b0;
      ea       <= '0;
      data_out <= '0;
      wb_val   <= '0;
      is_reg   <= 1'b0;
      is_imm   <= 1'b0;
    end else begin
      valid <= 1'b0;
      wb_en <= 1'b0;
      if (direct_done) begin
        valid    <= 1'b1;
        wb_en    <= res.wb_en;
        ea       <= res.ea;
        data_out <= res.data;
        wb_val   <= res.wb_val;
        is_reg   <= res.is_reg;
        is_imm   <= res.is_imm;
      end else if (fetch_done) begin
        valid    <= 1'b1;
        ea       <= mem_rdata;
        data_out <= '0;
        wb_val   <= '0;
        is_reg   <= 1'b0;
        is_imm   <= 1'b0;
      end
    end
  end

  a_r10_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode != AM_MEMIND |=> valid);
  a_r4_wb_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> valid && !is_reg && !is_imm);
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !(is_reg && is_imm));
  a_r12_wait_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !valid);
  a_r13_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !valid && !mem_req && !wb_en);
endmodule

// File: tb/sim_ea_unit.sv
module sim_ea_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic size_word = 1'b0;
  logic [15:0] reg_val = '0, field = '0, pc = '0, mem_rdata = '0;
  logic mem_ack = 1'b0;
  logic mem_req, valid, is_reg, is_imm, wb_en;
  logic [15:0] mem_addr, ea, data_out, wb_val;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ea_unit u0 (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .size_word(size_word), .reg_val(reg_val), .field(field), .pc(pc),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .valid(valid), .ea(ea), .data_out(data_out),
    .is_reg(is_reg), .is_imm(is_imm), .wb_en(wb_en), .wb_val(wb_val));

  typedef struct packed {
    logic [3:0]  md;
    logic        wd;
    logic [15:0] rv;
    logic [15:0] fl;
    logic [15:0] pcv;
    logic [15:0] x_ea;
    logic        x_wbe;
    logic [15:0] x_wb;
    logic        x_reg;
    logic        x_imm;
    logic [15:0] x_dat;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0, 16'h1234, 16'h0000, 16'h0000, 16'h1234, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{4'd2, 1'b0, 16'hF000, 16'h2345, 16'h0000, 16'h1345, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{4'd3, 1'b0, 16'h00FF, 16'h0000, 16'h0000, 16'h00FF, 1'b1, 16'h0100, 1'b0, 1'b0, 16'h0000},
    '{4'd3, 1'b1, 16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 16'h0001, 1'b0, 1'b0, 16'h0000},
    '{4'd4, 1'b1, 16'h0000, 16'h0000, 16'h0000, 16'hFFFE, 1'b1, 16'hFFFE, 1'b0, 1'b0, 16'h0000},
    '{4'd4, 1'b0, 16'h1000, 16'h0000, 16'h0000, 16'h0FFF, 1'b1, 16'h0FFF, 1'b0, 1'b0, 16'h0000},
    '{4'd5, 1'b0, 16'h0000, 16'hAB5C, 16'h0000, 16'hFF5C, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{4'd6, 1'b0, 16'h0000, 16'h4321, 16'h0000, 16'h4321, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{4'd7, 1'b0, 16'h0000, 16'h0080, 16'h1000, 16'h0F80, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{4'd7, 1'b0, 16'h0000, 16'h007F, 16'hFFF0, 16'h006F, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000},
    '{4'd0, 1'b1, 16'h7777, 16'h1111, 16'h2222, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000},
    '{4'd9, 1'b0, 16'h0000, 16'h12AB, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h00AB},
    '{4'd10,1'b1, 16'h0000, 16'hBEEF, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1, 16'hBEEF},
    '{4'd15,1'b0, 16'h5555, 16'h6666, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000}
  };

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd9, 4'd10: return "R11";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13", "valid", {15'd0, valid}, 16'd0);
    chk("R13", "mem_req", {15'd0, mem_req}, 16'd0);
    chk("R13", "wb_en", {15'd0, wb_en}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string t;
      v = VECS[i];
      t = tag_of(v.md);
      mode = v.md; size_word = v.wd; reg_val = v.rv; field = v.fl; pc = v.pcv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10", "valid", {15'd0, valid}, 16'd1);
      chk(t, "ea", ea, v.x_ea);
      chk(t, "wb_en", {15'd0, wb_en}, {15'd0, v.x_wbe});
      if (v.x_wbe) chk(t, "wb_val", wb_val, v.x_wb);
      chk(t, "is_reg", {15'd0, is_reg}, {15'd0, v.x_reg});
      chk(t, "is_imm", {15'd0, is_imm}, {15'd0, v.x_imm});
      chk(t, "data_out", data_out, v.x_dat);
      chk("R11", "no mem_req", {15'd0, mem_req}, 16'd0);
    end

    // R10: single-cycle valid pulse
    @(negedge clk);
    chk("R10", "valid drops", {15'd0, valid}, 16'd0);

    // R9: memory indirect with delayed acknowledge
    mode = 4'd8; field = 16'h7742; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "mem_req", {15'd0, mem_req}, 16'd1);
    chk("R9", "mem_addr", mem_addr, 16'h0042);
    chk("R10", "no valid while waiting", {15'd0, valid}, 16'd0);
    // R12: start during the wait is ignored
    mode = 4'd1; reg_val = 16'h5555; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R12", "valid", {15'd0, valid}, 16'd0);
    chk("R9", "mem_req held", {15'd0, mem_req}, 16'd1);
    chk("R9", "mem_addr held", mem_addr, 16'h0042);
    @(negedge clk);
    chk("R12", "valid later", {15'd0, valid}, 16'd0);
    mem_ack = 1'b1; mem_rdata = 16'hCAFE;
    @(negedge clk);
    mem_ack = 1'b0;
    chk("R10", "valid after ack", {15'd0, valid}, 16'd1);
    chk("R9", "ea", ea, 16'hCAFE);
    chk("R9", "mem_req released", {15'd0, mem_req}, 16'd0);
    chk("R9", "flags", {14'd0, is_reg, is_imm}, 16'd0);
    chk("R9", "wb_en", {15'd0, wb_en}, 16'd0);
    @(negedge clk);
    chk("R10", "valid one cycle", {15'd0, valid}, 16'd0);
    chk("R12", "no late result", {15'd0, mem_req}, 16'd0);

    // R11: immediate issues no memory request even in the following cycle
    mode = 4'd10; field = 16'h0102; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R11", "mem_req stays low", {15'd0, mem_req}, 16'd0);

    // R13: reset mid-operation clears request
    mode = 4'd8; field = 16'h0010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R13", "mem_req under reset", {15'd0, mem_req}, 16'd0);
    chk("R13", "valid under reset", {15'd0, valid}, 16'd0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule